// File: doc/BRIEF.md
# Sixteen-Bit ALU with Overflow Register

This block is the execute stage of a small 16-bit processor. Each cycle it can accept one basic operation, given as a 4-bit opcode and two 16-bit operands `a_i` and `b_i`. One clock later it presents the 16-bit result, a write-enable for the destination operand, a skip decision for conditional tests, and the base cycle cost of the instruction. The block holds a 16-bit overflow register. Arithmetic and shift operations load it with the part of their wide result that does not fit in 16 bits. Its current value is always visible at `ovf_o`.

Operand fetch, destination write-back and program-counter update stay outside the block. The surrounding sequencer uses `wr_en_o` to decide whether to store `res_o`, uses `skip_o` to step over the next instruction, and adds `cost_o` to its cycle counter.

Top module: `ovf_alu`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `vld_o`, `wr_en_o`, `skip_o`, `cost_o`, `res_o` and `ovf_o` are all zero.
- R2: `vld_o` equals `valid_i` from one clock earlier. When `vld_o` is low, `wr_en_o`, `skip_o`, `cost_o` and `res_o` are zero and the overflow register keeps its value.
- R3: Opcode 2 (add) gives `res_o` = (a+b) mod 2^16, asserts `wr_en_o`, and loads the overflow register with the carry, which is 0x0000 or 0x0001.
- R4: Opcode 3 (subtract) gives `res_o` = (a-b) mod 2^16 and loads the overflow register with 0xFFFF when a<b (unsigned), otherwise 0x0000.
- R5: Opcode 4 (multiply) returns the low 16 bits of the 32-bit unsigned product in `res_o` and loads the overflow register with the high 16 bits.
- R6: Opcode 5 (divide) returns the unsigned quotient and clears the overflow register. Opcode 6 (modulo) returns the remainder. Both return 0 when b is zero.
- R7: Opcode 7 (shift left) returns bits 15:0 of a<<b and loads the overflow register with bits 31:16. Opcode 8 (shift right) returns a>>b and loads the overflow register with bits 15:0 of (a<<16)>>b. A shift amount of 32 or more gives zero in both places.
- R8: Opcodes 1 (copy b), 6 (modulo), 9 (AND), 10 (OR) and 11 (XOR) assert `wr_en_o` and leave the overflow register unchanged.
- R9: The test opcodes 12 (equal), 13 (not equal), 14 (unsigned greater than) and 15 (any common bit set) never assert `wr_en_o` and never change the overflow register. `skip_o` is 1 exactly when the test fails.
- R10: `cost_o` is 1 for opcodes 1, 9, 10 and 11. It is 2 for opcodes 2, 3, 6, 7 and 8. It is 3 for opcodes 4 and 5. For test opcodes it is 2, or 3 when `skip_o` is 1.
- R11: Opcode 0 (reserved non-basic) asserts neither `wr_en_o` nor `skip_o`, reports `cost_o` = 0, and leaves the overflow register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| opc_i | input | 4 | Basic opcode |
| a_i | input | 16 | First operand (destination value) |
| b_i | input | 16 | Second operand |
| vld_o | output | 1 | Result of the operation issued one cycle earlier |
| res_o | output | 16 | Result word for the destination |
| wr_en_o | output | 1 | Destination must be written with `res_o` |
| ovf_o | output | 16 | Current overflow register |
| skip_o | output | 1 | Next instruction must be skipped |
| cost_o | output | 2 | Base cycle cost of the instruction |

## Verification
The block's only long-lived state is the overflow register. A wrong value in it is invisible while copy, logic and modulo operations run, and it is not exposed until the next idle check or the next operation whose expected overflow is compared. For that reason the stimulus places an overflow-preserving operation directly after each arithmetic operation that loads the register, and compares `ovf_o` on every result. The result register itself has a depth of one, so a decoding error in any opcode shows at `res_o`, `wr_en_o`, `skip_o` or `cost_o` exactly one cycle after issue.

// File: rtl/ovfalu_pkg.sv
package ovfalu_pkg;

    localparam int DATA_W = 16;
    localparam int COST_W = 2;

    typedef enum logic [3:0] {
        OP_EXT  = 4'd0,
        OP_MOV  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_MUL  = 4'd4,
        OP_DIV  = 4'd5,
        OP_MOD  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_AND  = 4'd9,
        OP_IOR  = 4'd10,
        OP_XOR  = 4'd11,
        OP_TEQ  = 4'd12,
        OP_TNE  = 4'd13,
        OP_TGT  = 4'd14,
        OP_TANY = 4'd15
    } op_e;

    // Result of one functional unit: low word for the destination,
    // high word for the overflow register.
    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } unit_res_t;

    // Complete registered state of the block.
    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              skip;
        logic [COST_W-1:0] cost;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] ovf;
    } step_t;

endpackage

// File: rtl/ovfalu_arith.sv
module ovfalu_arith
    import ovfalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);

    localparam int WW = 2 * W;

    logic [W:0]    sum_w;
    logic [WW-1:0] prod_w;
    logic          b_zero_w;
    logic [W-1:0]  quot_w;
    logic [W-1:0]  rem_w;

    always_comb begin
        sum_w    = {1'b0, a_i} + {1'b0, b_i};
        prod_w   = WW'(a_i) * WW'(b_i);
        b_zero_w = (b_i == '0);
        quot_w   = b_zero_w ? '0 : (a_i / b_i);
        rem_w    = b_zero_w ? '0 : (a_i % b_i);
    end

    always_comb begin
        lo_o = '0;
        hi_o = '0;
        case (op_i)
            OP_ADD: begin
                lo_o = sum_w[W-1:0];
                hi_o = {{(W-1){1'b0}}, sum_w[W]};
            end
            OP_SUB: begin
                lo_o = a_i - b_i;
                hi_o = (a_i < b_i) ? '1 : '0;
            end
            OP_MUL: begin
                lo_o = prod_w[W-1:0];
                hi_o = prod_w[WW-1:W];
            end
            OP_DIV: begin
                lo_o = quot_w;
                hi_o = '0;
            end
            OP_MOD: begin
                lo_o = rem_w;
                hi_o = '0;
            end
            default: begin
                lo_o = '0;
                hi_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ovfalu_shift.sv
module ovfalu_shift
    import ovfalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         right_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);

    localparam int WW   = 2 * W;
    localparam int SH_W = $clog2(WW);

    logic [SH_W-1:0] amt_w;
    logic            far_w;
    logic [WW-1:0]   lstg [0:SH_W];
    logic [WW-1:0]   rstg [0:SH_W];

    assign amt_w   = b_i[SH_W-1:0];
    assign far_w   = |b_i[W-1:SH_W];
    assign lstg[0] = {{W{1'b0}}, a_i};
    assign rstg[0] = {a_i, {W{1'b0}}};

    // Logarithmic barrel: stage k moves the word by 2**k places.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign lstg[k+1] = amt_w[k] ? (lstg[k] << (2 ** k)) : lstg[k];
        assign rstg[k+1] = amt_w[k] ? (rstg[k] >> (2 ** k)) : rstg[k];
    end

    always_comb begin
        if (far_w) begin
            lo_o = '0;
            hi_o = '0;
        end else if (right_i) begin
            lo_o = rstg[SH_W][WW-1:W];
            hi_o = rstg[SH_W][W-1:0];
        end else begin
            lo_o = lstg[SH_W][W-1:0];
            hi_o = lstg[SH_W][WW-1:W];
        end
    end

endmodule

// File: rtl/ovfalu_logic.sv
module ovfalu_logic
    import ovfalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic         pass_o
);

    always_comb begin
        lo_o   = '0;
        pass_o = 1'b1;
        case (op_i)
            OP_MOV:  lo_o   = b_i;
            OP_AND:  lo_o   = a_i & b_i;
            OP_IOR:  lo_o   = a_i | b_i;
            OP_XOR:  lo_o   = a_i ^ b_i;
            OP_TEQ:  pass_o = (a_i == b_i);
            OP_TNE:  pass_o = (a_i != b_i);
            OP_TGT:  pass_o = (a_i > b_i);
            OP_TANY: pass_o = |(a_i & b_i);
            default: begin
                lo_o   = '0;
                pass_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
    import ovfalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        opc_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] ovf_o,
    output logic              skip_o,
    output logic [COST_W-1:0] cost_o
);

    op_e               op_w;
    logic [DATA_W-1:0] ar_lo_w, ar_hi_w;
    logic [DATA_W-1:0] sh_lo_w, sh_hi_w;
    logic [DATA_W-1:0] lg_lo_w;
    logic              lg_pass_w;
    step_t             st_d, st_q;

    assign op_w = op_e'(opc_i);

    ovfalu_arith #(.W(DATA_W)) u_arith (
        .op_i (op_w),
        .a_i  (a_i),
        .b_i  (b_i),
        .lo_o (ar_lo_w),
        .hi_o (ar_hi_w)
    );

    ovfalu_shift #(.W(DATA_W)) u_shift (
        .right_i (op_w == OP_SHR),
        .a_i     (a_i),
        .b_i     (b_i),
        .lo_o    (sh_lo_w),
        .hi_o    (sh_hi_w)
    );

    ovfalu_logic #(.W(DATA_W)) u_logic (
        .op_i   (op_w),
        .a_i    (a_i),
        .b_i    (b_i),
        .lo_o   (lg_lo_w),
        .pass_o (lg_pass_w)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = valid_i;
        st_d.ovf = st_q.ovf;
        if (valid_i) begin
            case (op_w)
                OP_MOV, OP_AND, OP_IOR, OP_XOR: begin
                    st_d.res  = lg_lo_w;
                    st_d.wr   = 1'b1;
                    st_d.cost = COST_W'(1);
                end
                OP_ADD, OP_SUB: begin
                    st_d.res  = ar_lo_w;
                    st_d.ovf  = ar_hi_w;
                    st_d.wr   = 1'b1;
                    st_d.cost = COST_W'(2);
                end
                OP_MUL, OP_DIV: begin
                    st_d.res  = ar_lo_w;
                    st_d.ovf  = ar_hi_w;
                    st_d.wr   = 1'b1;
                    st_d.cost = COST_W'(3);
                end
                OP_MOD: begin
                    st_d.res  = ar_lo_w;
                    st_d.wr   = 1'b1;
                    st_d.cost = COST_W'(2);
                end
                OP_SHL, OP_SHR: begin
                    st_d.res  = sh_lo_w;
                    st_d.ovf  = sh_hi_w;
                    st_d.wr   = 1'b1;
                    st_d.cost = COST_W'(2);
                end
                OP_TEQ, OP_TNE, OP_TGT, OP_TANY: begin
                    st_d.skip = ~lg_pass_w;
                    st_d.cost = lg_pass_w ? COST_W'(2) : COST_W'(3);
                end
                default: begin
                    st_d.cost = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o   = st_q.vld;
    assign res_o   = st_q.res;
    assign wr_en_o = st_q.wr;
    assign ovf_o   = st_q.ovf;
    assign skip_o  = st_q.skip;
    assign cost_o  = st_q.cost;

endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk
    import ovfalu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        opc_i,
    input logic [DATA_W-1:0] b_i,
    input logic              vld_o,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [DATA_W-1:0] ovf_o,
    input logic              skip_o,
    input logic [COST_W-1:0] cost_o
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == $past(valid_i));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (!wr_en_o && !skip_o && cost_o == '0 && res_o == '0 && $stable(ovf_o)));

    p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(opc_i == 4'd2)) |-> (ovf_o <= DATA_W'(1)));

    p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(opc_i == 4'd3)) |-> (ovf_o == '0 || ovf_o == '1));

    p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(opc_i == 4'd5 && b_i == '0)) |-> (res_o == '0 && ovf_o == '0));

    p_keep_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(opc_i inside {4'd1, 4'd6, 4'd9, 4'd10, 4'd11}))
        |-> (wr_en_o && $stable(ovf_o)));

    p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (!wr_en_o && $stable(ovf_o)));

    p_skip_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (cost_o == COST_W'(3)));

    p_ext_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(opc_i == 4'd0)) |-> (!wr_en_o && !skip_o && cost_o == '0));

endmodule

bind ovf_alu ovf_alu_chk u_chk (.*);

// File: tb/ovf_alu_tb_top.sv
module ovf_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  opc_i = 4'd0;
    logic [15:0] a_i = 16'd0;
    logic [15:0] b_i = 16'd0;
    logic        vld_o;
    logic [15:0] res_o;
    logic        wr_en_o;
    logic [15:0] ovf_o;
    logic        skip_o;
    logic [1:0]  cost_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [15:0] res;
        logic        wr;
        logic        skip;
        logic [1:0]  cost;
        logic [15:0] ovf;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [15:0] m_ovf = 16'd0;

    always #2 clk = ~clk;

    ovf_alu dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .opc_i   (opc_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .vld_o   (vld_o),
        .res_o   (res_o),
        .wr_en_o (wr_en_o),
        .ovf_o   (ovf_o),
        .skip_o  (skip_o),
        .cost_o  (cost_o)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [3:0] op, input logic [15:0] a,
                                   input logic [15:0] b, input logic [15:0] ovf);
        exp_t e;
        logic [31:0] wide;
        e = '0;
        e.ovf = ovf;
        case (op)
            4'd1:  begin e.res = b;      e.wr = 1; e.cost = 1; end
            4'd2:  begin wide = {16'd0, a} + {16'd0, b};
                         e.res = wide[15:0]; e.ovf = wide[31:16]; e.wr = 1; e.cost = 2; end
            4'd3:  begin e.res = a - b; e.ovf = (a < b) ? 16'hFFFF : 16'h0000;
                         e.wr = 1; e.cost = 2; end
            4'd4:  begin wide = {16'd0, a} * {16'd0, b};
                         e.res = wide[15:0]; e.ovf = wide[31:16]; e.wr = 1; e.cost = 3; end
            4'd5:  begin e.res = (b == 0) ? 16'd0 : a / b; e.ovf = 16'd0; e.wr = 1; e.cost = 3; end
            4'd6:  begin e.res = (b == 0) ? 16'd0 : a % b; e.wr = 1; e.cost = 2; end
            4'd7:  begin wide = {16'd0, a} << b;
                         e.res = wide[15:0]; e.ovf = wide[31:16]; e.wr = 1; e.cost = 2; end
            4'd8:  begin e.res = a >> b; wide = {a, 16'd0} >> b;
                         e.ovf = wide[15:0]; e.wr = 1; e.cost = 2; end
            4'd9:  begin e.res = a & b; e.wr = 1; e.cost = 1; end
            4'd10: begin e.res = a | b; e.wr = 1; e.cost = 1; end
            4'd11: begin e.res = a ^ b; e.wr = 1; e.cost = 1; end
            4'd12: begin e.skip = (a != b);        e.cost = e.skip ? 2'd3 : 2'd2; end
            4'd13: begin e.skip = (a == b);        e.cost = e.skip ? 2'd3 : 2'd2; end
            4'd14: begin e.skip = (a <= b);        e.cost = e.skip ? 2'd3 : 2'd2; end
            4'd15: begin e.skip = ((a & b) == 0);  e.cost = e.skip ? 2'd3 : 2'd2; end
            default: e.cost = 0;
        endcase
        return e;
    endfunction

    // Driver: issues one operation and queues its expected result.
    task automatic send(input logic [3:0] op, input logic [15:0] a,
                        input logic [15:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        valid_i = 1'b1;
        opc_i   = op;
        a_i     = a;
        b_i     = b;
        e = model(op, a, b, m_ovf);
        m_ovf = e.ovf;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        valid_i = 1'b0;
        opc_i   = 4'd0;
        a_i     = 16'hDEAD;
        b_i     = 16'hBEEF;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // Checked at a negedge with no operation in flight (R2).
    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (vld_o !== 1'b0 || wr_en_o !== 1'b0 || skip_o !== 1'b0 ||
            cost_o !== 2'd0 || ovf_o !== m_ovf) begin
            fails++;
            $display("FAIL %s idle: vld=%b wr=%b skip=%b cost=%0d ovf=%h expected 0 0 0 0 ovf=%h",
                     tag, vld_o, wr_en_o, skip_o, cost_o, ovf_o, m_ovf);
        end
    endtask

    // Monitor: compares every produced result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && vld_o && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected result res=%h, expected no result", res_o);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (res_o !== e.res || wr_en_o !== e.wr || skip_o !== e.skip ||
                    cost_o !== e.cost || ovf_o !== e.ovf) begin
                    fails++;
                    $display("FAIL %s: got res=%h wr=%b skip=%b cost=%0d ovf=%h expected res=%h wr=%b skip=%b cost=%0d ovf=%h",
                             t, res_o, wr_en_o, skip_o, cost_o, ovf_o,
                             e.res, e.wr, e.skip, e.cost, e.ovf);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: outputs zero while reset is held
        @(negedge clk);
        checks++;
        if ({vld_o, wr_en_o, skip_o, cost_o, res_o, ovf_o} !== '0) begin
            fails++;
            $display("FAIL R1: outputs %b expected all zero",
                     {vld_o, wr_en_o, skip_o, cost_o, res_o, ovf_o});
        end
        rst_n = 1'b1;
        check_idle("R1");

        // Arithmetic with back-to-back issue
        send(4'd1,  16'h0001, 16'h1234, "R8");
        send(4'd2,  16'hFFFF, 16'h0002, "R3");
        send(4'd1,  16'h0000, 16'h5555, "R8");
        send(4'd2,  16'h0001, 16'h0002, "R3");
        send(4'd3,  16'h0005, 16'h0007, "R4");
        send(4'd9,  16'hF0F0, 16'h3C3C, "R8");
        send(4'd3,  16'h0007, 16'h0005, "R4");
        send(4'd4,  16'h1234, 16'h5678, "R5");
        send(4'd10, 16'hF000, 16'h000F, "R8");
        send(4'd4,  16'hFFFF, 16'hFFFF, "R5");
        send(4'd5,  16'h1234, 16'h0000, "R6");
        send(4'd4,  16'h8000, 16'h0004, "R5");
        send(4'd5,  16'd100,  16'd7,    "R6");
        send(4'd4,  16'h4000, 16'h0010, "R5");
        send(4'd6,  16'd17,   16'd5,    "R6");
        send(4'd6,  16'hABCD, 16'h0000, "R6");
        idle(2);
        check_idle("R2");

        // Shifts
        send(4'd7,  16'h8001, 16'd1,    "R7");
        send(4'd11, 16'hAAAA, 16'hFFFF, "R8");
        send(4'd7,  16'h00FF, 16'd20,   "R7");
        send(4'd7,  16'hFFFF, 16'd40,   "R7");
        send(4'd8,  16'h0003, 16'd1,    "R7");
        send(4'd8,  16'h8421, 16'd17,   "R7");
        send(4'd8,  16'hFFFF, 16'd100,  "R7");
        send(4'd8,  16'h1234, 16'd0,    "R7");
        send(4'd4,  16'h0100, 16'h0100, "R5");

        // Conditional tests, both outcomes (R9, R10)
        send(4'd12, 16'h0042, 16'h0042, "R9");
        send(4'd12, 16'h0042, 16'h0043, "R9");
        send(4'd13, 16'h0042, 16'h0042, "R9");
        send(4'd13, 16'h0001, 16'h0002, "R9");
        send(4'd14, 16'h0005, 16'h0005, "R9");
        send(4'd14, 16'h8000, 16'h7FFF, "R9");
        send(4'd15, 16'hF0F0, 16'h0F0F, "R10");
        send(4'd15, 16'hF0F0, 16'h1010, "R10");

        // Reserved opcode
        send(4'd0,  16'h1111, 16'h2222, "R11");
        idle(3);
        check_idle("R11");

        // Idle cycles with operand noise between issues
        send(4'd2,  16'h8000, 16'h8000, "R3");
        idle(4);
        check_idle("R2");
        send(4'd3,  16'h0000, 16'h0001, "R4");
        idle(2);
        check_idle("R2");

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule